// File: doc/BRIEF.md
# Floating-Point Coprocessor Issue Scoreboard

This block sits at the issue stage of a floating-point coprocessor with three execution pipes: multiply-accumulate (MAC), divide/square-root (DIV) and load/store (LS). Each cycle it looks at one candidate instruction. The instruction is given as a 3-bit class code, a destination register and up to two source registers, each source with its own use bit. The block accepts the instruction in the same cycle or refuses it. It refuses when a pipe entry stage the instruction needs is still booked, when a flag transfer meets a busy arithmetic pipe, or when a used source register's result is not yet available.

On acceptance the block books each pipe for as many cycles as the class holds it. It also loads a per-register countdown with the class latency, so that a consumer may issue exactly that many cycles after its producer. Each pipe booking is tracked by a small two-state machine. The states are PT_IDLE and PT_BUSY. The transitions are LOAD_BUSY (PT_IDLE or PT_BUSY to PT_BUSY on a non-zero booking), LOAD_IDLE (to PT_IDLE on a zero booking), EXPIRE (PT_BUSY to PT_IDLE when the count reaches its last cycle) and HOLD (stay otherwise). Arithmetic, register contents and write-after-read ordering lie outside the block.

Top module: `fpsb_issue_ctl`

## Requirements
- R1: A synchronous reset clears every pipe booking and every register countdown. The first instruction after reset is accepted in its own cycle, even when the reset cut off long bookings.
- R2: `issue_accept` is high exactly when `req_valid` is high and no hazard exists. `issue_stall` is high exactly when `req_valid` is high and a hazard exists. Both are low when `req_valid` is low.
- R3: Class 0 (fast arithmetic, latency 4) and class 1 (general arithmetic or conversion, latency 8) hold the MAC pipe only in their issue cycle. A MAC user in the next cycle is accepted.
- R4: Class 2 (multiply, latency 9) holds the MAC pipe in its issue cycle and the next one. A MAC user one cycle later is refused, and two cycles later it is accepted.
- R5: Class 3 (single divide, latency 19) holds the DIV pipe for 15 cycles. Another DIV user is refused 1 to 14 cycles later and accepted 15 cycles later.
- R6: Class 4 (double divide, latency 33) holds the MAC pipe only in its issue cycle and the DIV pipe for 29 cycles. A MAC user one cycle later is accepted. A DIV user is refused until 29 cycles later.
- R7: Class 5 (load, store or core transfer, latency 4) holds the LS pipe only in its issue cycle.
- R8: Class 6 (flag transfer, latency 4) is refused while the MAC or DIV pipe is booked. On issue it books the LS pipe for the 3 cycles after its issue cycle. An LS user is refused 1 to 3 cycles later, and a second flag transfer is accepted 3 cycles later.
- R9: A used source whose producer issued L cycles earlier (L the producer's class latency) is refused for fewer than L cycles and accepted at L.
- R10: A source register whose use bit is low has no effect on acceptance.
- R11: A refused instruction books no pipe and changes no register countdown.
- R12: Class 7 is a no-op. It needs no pipe, is accepted even while every pipe is booked, and leaves its destination register's countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Candidate instruction present |
| req_class | input | 3 | Instruction class code (0..7) |
| req_dst | input | 5 | Destination register number |
| req_src_a | input | 5 | First source register number |
| req_use_a | input | 1 | First source is read |
| req_src_b | input | 5 | Second source register number |
| req_use_b | input | 1 | Second source is read |
| issue_accept | output | 1 | Candidate issues this cycle |
| issue_stall | output | 1 | Candidate is refused this cycle |

## Verification
The structural check and the data check can refuse the same candidate in the same cycle. The bench provokes this with a flag transfer, which books the LS pipe and writes a register, followed by a load that reads that register. The load is refused for three cycles on both counts. It must then be accepted at exactly four cycles, when the LS booking ends and the latency expires together. Reset is also made to fall on a cycle where a double divide holds the DIV pipe and a register countdown. It must release both at once.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    localparam int NUM_PIPES = 3;
    localparam int PIPE_MAC  = 0;
    localparam int PIPE_DIV  = 1;
    localparam int PIPE_LS   = 2;

    localparam int LAT_FAST  = 4;
    localparam int LAT_ARITH = 8;
    localparam int LAT_MUL   = 9;
    localparam int LAT_DIVS  = 19;
    localparam int LAT_DIVD  = 33;
    localparam int LAT_XFER  = 4;
    localparam int LAT_FLAG  = 4;

    localparam int OCC_MUL_MAC  = 2;
    localparam int OCC_DIVS_DIV = 15;
    localparam int OCC_DIVD_DIV = 29;
    localparam int OCC_FLAG_LS  = 3;

    localparam int LAT_W = $clog2(LAT_DIVD + 1);
    localparam int OCC_W = $clog2(OCC_DIVD_DIV + 1);

    typedef enum logic [2:0] {
        C_FAST  = 3'd0,
        C_ARITH = 3'd1,
        C_MUL   = 3'd2,
        C_DIVS  = 3'd3,
        C_DIVD  = 3'd4,
        C_XFER  = 3'd5,
        C_FLAG  = 3'd6,
        C_NOP   = 3'd7
    } op_class_e;

    typedef struct packed {
        logic [LAT_W-1:0]                 lat;
        logic                             wr;
        logic                             flag;
        logic [NUM_PIPES-1:0]             need;
        logic [NUM_PIPES-1:0][1:0]        start;
        logic [NUM_PIPES-1:0][OCC_W-1:0]  reload;
    } booking_t;

    function automatic booking_t decode_class(op_class_e c);
        booking_t b;
        b = '0;
        unique case (c)
            C_FAST: begin
                b.lat = LAT_W'(LAT_FAST); b.wr = 1'b1;
                b.need[PIPE_MAC] = 1'b1;
            end
            C_ARITH: begin
                b.lat = LAT_W'(LAT_ARITH); b.wr = 1'b1;
                b.need[PIPE_MAC] = 1'b1;
            end
            C_MUL: begin
                b.lat = LAT_W'(LAT_MUL); b.wr = 1'b1;
                b.need[PIPE_MAC] = 1'b1;
                b.reload[PIPE_MAC] = OCC_W'(OCC_MUL_MAC - 1);
            end
            C_DIVS: begin
                b.lat = LAT_W'(LAT_DIVS); b.wr = 1'b1;
                b.need[PIPE_DIV] = 1'b1;
                b.reload[PIPE_DIV] = OCC_W'(OCC_DIVS_DIV - 1);
            end
            C_DIVD: begin
                b.lat = LAT_W'(LAT_DIVD); b.wr = 1'b1;
                b.need[PIPE_MAC] = 1'b1;
                b.need[PIPE_DIV] = 1'b1;
                b.reload[PIPE_DIV] = OCC_W'(OCC_DIVD_DIV - 1);
            end
            C_XFER: begin
                b.lat = LAT_W'(LAT_XFER); b.wr = 1'b1;
                b.need[PIPE_LS] = 1'b1;
            end
            C_FLAG: begin
                b.lat = LAT_W'(LAT_FLAG); b.wr = 1'b1; b.flag = 1'b1;
                b.need[PIPE_LS] = 1'b1;
                b.start[PIPE_LS] = 2'd1;
                b.reload[PIPE_LS] = OCC_W'(OCC_FLAG_LS);
            end
            C_NOP: begin
                b = '0;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fpsb_pipe_timer.sv
module fpsb_pipe_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          busy
);

    typedef enum logic {PT_IDLE, PT_BUSY} pt_state_e;
    pt_state_e state, state_nx;

    // next-state: LOAD_BUSY, LOAD_IDLE, EXPIRE, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            PT_IDLE: if (load && load_val != '0) state_nx = PT_BUSY;
            PT_BUSY: begin
                if (load) state_nx = (load_val != '0) ? PT_BUSY : PT_IDLE;
                else if (cnt == CW'(1)) state_nx = PT_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PT_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    always_comb begin
        busy = (state == PT_BUSY);
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && state == PT_IDLE));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (state == PT_IDLE && !load) |=> (state == PT_IDLE));

    assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PT_BUSY && !load) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/fpsb_reg_ready.sv
module fpsb_reg_ready #(
    parameter int NREG  = 32,
    parameter int LAT_W = 6,
    localparam int RW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RW-1:0]    load_dst,
    input  logic [LAT_W-1:0] load_val,
    input  logic [RW-1:0]    src_a,
    input  logic [RW-1:0]    src_b,
    output logic             ready_a,
    output logic             ready_b
);

    logic [LAT_W-1:0] left [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                  left[i] <= '0;
            else if (load && load_dst == RW'(i))      left[i] <= load_val;
            else if (left[i] != '0)                   left[i] <= left[i] - LAT_W'(1);
        end

        assert_reg_drain_R9: assert property (@(posedge clk) disable iff (rst)
            (left[i] != '0 && !(load && load_dst == RW'(i)))
            |=> (left[i] == $past(left[i]) - LAT_W'(1)));
    end

    assign ready_a = (left[src_a] == '0);
    assign ready_b = (left[src_b] == '0);

endmodule

// File: rtl/fpsb_issue_ctl.sv
module fpsb_issue_ctl
    import fpsb_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_class,
    input  logic [RW-1:0] req_dst,
    input  logic [RW-1:0] req_src_a,
    input  logic          req_use_a,
    input  logic [RW-1:0] req_src_b,
    input  logic          req_use_b,
    output logic          issue_accept,
    output logic          issue_stall
);

    booking_t               bk;
    logic [NUM_PIPES-1:0]   pipe_busy;
    logic [NUM_PIPES-1:0]   pipe_fits;
    logic [OCC_W-1:0]       pipe_cnt [NUM_PIPES];
    logic                   struct_ok, excl_ok, src_ok, ready_a, ready_b, go;

    assign bk = decode_class(op_class_e'(req_class));

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        fpsb_pipe_timer #(.CW(OCC_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .load     (go && bk.need[p]),
            .load_val (bk.reload[p]),
            .cnt      (pipe_cnt[p]),
            .busy     (pipe_busy[p])
        );
        assign pipe_fits[p] = !bk.need[p] || (pipe_cnt[p] <= OCC_W'(bk.start[p]));
    end

    fpsb_reg_ready #(.NREG(NREG), .LAT_W(LAT_W)) u_ready (
        .clk      (clk),
        .rst      (rst),
        .load     (go && bk.wr),
        .load_dst (req_dst),
        .load_val (bk.lat - LAT_W'(1)),
        .src_a    (req_src_a),
        .src_b    (req_src_b),
        .ready_a  (ready_a),
        .ready_b  (ready_b)
    );

    always_comb begin
        struct_ok = &pipe_fits;
        excl_ok   = !bk.flag || !(pipe_busy[PIPE_MAC] || pipe_busy[PIPE_DIV]);
        src_ok    = (!req_use_a || ready_a) && (!req_use_b || ready_b);
        go        = req_valid && struct_ok && excl_ok && src_ok;
    end

    always_comb begin
        issue_accept = go;
        issue_stall  = req_valid && !go;
    end

    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
        !(issue_accept && issue_stall));

    assert_mul_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_accept && req_class == 3'd2) |=>
        !(issue_accept && (req_class inside {3'd0, 3'd1, 3'd2, 3'd4})));

    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_accept && req_class == 3'd6) |->
        (!pipe_busy[PIPE_MAC] && !pipe_busy[PIPE_DIV]));

    assert_flag_ls_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_accept && req_class == 3'd6) |=> ##1
        !(issue_accept && req_class == 3'd5));

endmodule

// File: tb/fpsb_issue_ctl_test.sv
module fpsb_issue_ctl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = '0;
    logic [4:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
    logic       req_use_a = 1'b0, req_use_b = 1'b0;
    logic       issue_accept, issue_stall;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    fpsb_issue_ctl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_dst(req_dst), .req_src_a(req_src_a), .req_use_a(req_use_a),
        .req_src_b(req_src_b), .req_use_b(req_use_b),
        .issue_accept(issue_accept), .issue_stall(issue_stall)
    );

    task automatic cyc(input bit v, input int cls, input int dst, input int sa,
                       input bit ua, input bit exp, input string tag,
                       input int sb = 0, input bit ub = 1'b0);
        @(negedge clk);
        req_valid = v; req_class = 3'(cls); req_dst = 5'(dst);
        req_src_a = 5'(sa); req_use_a = ua; req_src_b = 5'(sb); req_use_b = ub;
        #1;
        checks++;
        if (issue_accept !== exp || issue_stall !== (v & ~exp)) begin
            fails++;
            $display("FAIL %s: accept=%b stall=%b expected accept=%b stall=%b",
                     tag, issue_accept, issue_stall, exp, v & ~exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "R2 idle");
    endtask

    task automatic t_reset;
        idle(2);
        cyc(1, 4, 9, 0, 0, 1, "R1 first after reset");
        cyc(1, 3, 10, 0, 0, 0, "R5 div busy before reset");
        @(negedge clk); req_valid = 0; rst = 1;
        @(negedge clk); rst = 0;
        cyc(1, 3, 11, 9, 1, 1, "R1 div and reg cleared by reset");
        idle(20);
    endtask

    task automatic t_fast;
        cyc(1, 0, 1, 0, 0, 1, "R3 fast");
        cyc(1, 1, 2, 0, 0, 1, "R3 arith after fast");
        cyc(1, 0, 3, 0, 0, 1, "R3 fast after arith");
        idle(10);
    endtask

    task automatic t_mul;
        cyc(1, 2, 1, 0, 0, 1, "R4 mul");
        cyc(1, 1, 2, 0, 0, 0, "R4 mac user at +1");
        cyc(1, 1, 2, 0, 0, 1, "R4 mac user at +2");
        idle(10);
    endtask

    task automatic t_divs;
        cyc(1, 3, 1, 0, 0, 1, "R5 divs");
        for (int k = 1; k < 15; k++) cyc(1, 3, 2, 0, 0, 0, "R5 div busy");
        cyc(1, 3, 2, 0, 0, 1, "R5 div free at +15");
        idle(20);
    endtask

    task automatic t_divd;
        cyc(1, 4, 1, 0, 0, 1, "R6 divd");
        cyc(1, 0, 2, 0, 0, 1, "R6 mac free at +1");
        cyc(1, 6, 3, 0, 0, 0, "R8 flag refused while div busy");
        for (int k = 3; k < 29; k++) cyc(1, 3, 4, 0, 0, 0, "R6 div busy");
        cyc(1, 3, 4, 0, 0, 1, "R6 div free at +29");
        idle(20);
    endtask

    task automatic t_xfer;
        cyc(1, 5, 1, 0, 0, 1, "R7 xfer");
        cyc(1, 5, 2, 0, 0, 1, "R7 xfer at +1");
        cyc(1, 5, 3, 0, 0, 1, "R7 xfer at +2");
        idle(5);
    endtask

    task automatic t_flag;
        cyc(1, 6, 1, 0, 0, 1, "R8 flag");
        for (int k = 1; k < 4; k++) cyc(1, 5, 2, 0, 0, 0, "R8 ls booked");
        cyc(1, 5, 2, 0, 0, 1, "R8 ls free at +4");
        idle(5);
        cyc(1, 6, 3, 0, 0, 1, "R8 flag a");
        cyc(1, 6, 4, 0, 0, 0, "R8 flag at +1");
        cyc(1, 6, 4, 0, 0, 0, "R8 flag at +2");
        cyc(1, 6, 4, 0, 0, 1, "R8 flag at +3");
        idle(5);
        cyc(1, 2, 5, 0, 0, 1, "R8 mul before flag");
        cyc(1, 6, 6, 0, 0, 0, "R8 flag vs mac busy");
        cyc(1, 6, 6, 0, 0, 1, "R8 flag after mac");
        idle(5);
    endtask

    task automatic t_lat(input int cls, input int lat, input int dst, input bit via_b);
        cyc(1, cls, dst, 0, 0, 1, "R9 producer");
        for (int k = 1; k < lat; k++)
            cyc(1, 5, 20, via_b ? 0 : dst, !via_b, 0, "R9 consumer early", via_b ? dst : 0, via_b);
        cyc(1, 5, 20, via_b ? 0 : dst, !via_b, 1, "R9 consumer at latency", via_b ? dst : 0, via_b);
        idle(36);
    endtask

    task automatic t_use_bits;
        cyc(1, 2, 5, 0, 0, 1, "R10 producer");
        cyc(1, 5, 6, 5, 0, 1, "R10 unused src a", 5, 0);
        cyc(1, 5, 6, 5, 1, 0, "R10 used src a");
        idle(10);
    endtask

    task automatic t_refused;
        cyc(1, 2, 6, 0, 0, 1, "R11 mul");
        cyc(1, 2, 7, 0, 0, 0, "R11 mul refused");
        cyc(1, 1, 8, 0, 0, 1, "R11 refused mul booked nothing");
        cyc(1, 5, 9, 7, 1, 1, "R11 refused dst not pending");
        idle(12);
    endtask

    task automatic t_nop;
        cyc(1, 4, 12, 0, 0, 1, "R12 divd");
        cyc(1, 7, 13, 0, 0, 1, "R12 nop while pipes busy");
        cyc(1, 5, 14, 13, 1, 1, "R12 nop dst untouched");
        idle(35);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_fast;
        t_mul;
        t_divs;
        t_divd;
        t_xfer;
        t_flag;
        t_lat(0, 4, 21, 0);
        t_lat(1, 8, 22, 1);
        t_lat(2, 9, 23, 0);
        t_lat(3, 19, 24, 1);
        t_lat(4, 33, 25, 0);
        t_lat(5, 4, 26, 1);
        t_lat(6, 4, 27, 0);
        t_use_bits;
        t_refused;
        t_nop;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule